// File: doc/BRIEF.md
# DMA Bridge Event Interrupt Aggregator

This block gathers ten single-cycle event pulses from a DMA bridge and turns them into three level interrupt requests. Two events come from a USB transfer path (transfer complete, address fault) and eight from two audio channels. Each audio channel has a playback and a capture direction, and each direction signals both buffer-complete and buffer-half events. Every event owns a sticky status flag and an enable flag. Both kinds of flag live in one 32-bit register, which is reached through a plain write strobe with write data and a combinational read bus.

Software acknowledges an event by writing a zero into its status flag. A one written into a status flag leaves it alone, so a read-modify-write sequence cannot set flags by accident. An event drives its interrupt line only while its status flag and its enable flag are both set. The enable flag always sits eight bit positions above its status flag. The three lines OR mixed groups of events. The USB transfer-complete event shares a line with the audio buffer-complete events.

Top module: `dma_evt_irq_agg`

## Requirements
- R1: Event k (0..9) sets status bit k for k < 2 and status bit k+14 for k >= 2. Event 0 is USB transfer complete and event 1 is USB address fault. Events 2..9 are ch0 play full, ch0 play half, ch0 capture full, ch0 capture half, then the same four for ch1.
- R2: A one-cycle strobe on evtStrobe[k] sets that event's status flag whatever the state of its enable flag. The flag is visible on rdData one cycle after the strobe.
- R3: A status flag stays set until a write carries a 0 in its bit position, which clears it. A write with a 1 there has no effect.
- R4: When a strobe and a clearing write arrive in the same cycle, the status flag ends up set.
- R5: Each enable flag sits 8 bits above its status flag (bits 9..8 and 31..24). Every write loads all enable flags from wrData.
- R6: Bits 15..10 and 7..2 always read as zero, whatever has been written.
- R7: irqLine[0] is driven only by event 1.
- R8: irqLine[1] is driven by events 0, 2, 4, 6 and 8.
- R9: irqLine[2] is driven by events 3, 5, 7 and 9.
- R10: Each line is the registered OR of its group's events that have both status and enable set. A line rises one cycle after its status flag becomes visible. It falls one cycle after the last qualifying flag is cleared or masked.
- R11: After reset, rdData and irqLine are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Write data |
| evtStrobe | input | 10 | One-cycle event pulses, bit k is event k |
| rdData | output | 32 | Current register contents |
| irqLine | output | 3 | Level interrupt requests, active high |

## Verification
The assertions assume that the event strobes and the write port are sampled synchronously to clk, and that rdData reflects the register state with no delay. On that basis a flag seen on the read bus stands for the datapath state. The checks also assume that a write always carries a full register image, so every write reloads every enable flag. The stimulus drives each input just after a falling edge, holds it for exactly one rising edge, and always writes complete images. These images are built from the bit positions given in R1 and R5.

// File: rtl/evt_agg_pkg.sv
package evt_agg_pkg;
  localparam int REG_W      = 32;
  localparam int EVT_CNT    = 10;
  localparam int USB_CNT    = 2;
  localparam int AUD_STAT0  = 16;
  localparam int EN_OFFSET  = 8;
  localparam int IRQ_CNT    = 3;
  localparam int AUD_SHIFT  = AUD_STAT0 - USB_CNT;

  typedef struct packed {
    logic [EVT_CNT-1:0] setMask;
    logic [EVT_CNT-1:0] clrMask;
    logic               enWr;
    logic [EVT_CNT-1:0] enVal;
  } ctlStrobes_t;

  function automatic int statPos(input int k);
    return (k < USB_CNT) ? k : k + AUD_SHIFT;
  endfunction

  function automatic int enPos(input int k);
    return statPos(k) + EN_OFFSET;
  endfunction

  // line 0: address fault; line 1: transfer complete + buffer full; line 2: buffer half
  function automatic int evtLine(input int k);
    if (k == 1) return 0;
    if (k == 0 || (k % 2) == 0) return 1;
    return 2;
  endfunction
endpackage

// File: rtl/evt_agg_ctl.sv
module evt_agg_ctl
  import evt_agg_pkg::*;
(
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  input  logic [EVT_CNT-1:0] evtStrobe,
  output ctlStrobes_t        ctl
);
  always_comb begin
    ctl.setMask = evtStrobe;
    ctl.enWr    = wrEn;
    for (int k = 0; k < EVT_CNT; k++) begin
      ctl.clrMask[k] = wrEn & ~wrData[statPos(k)];
      ctl.enVal[k]   = wrData[enPos(k)];
    end
  end
endmodule

// File: rtl/evt_agg_dp.sv
module evt_agg_dp
  import evt_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  ctlStrobes_t        ctl,
  output logic [REG_W-1:0]   rdData,
  output logic [IRQ_CNT-1:0] irqLine
);
  logic [EVT_CNT-1:0] statQ;
  logic [EVT_CNT-1:0] enQ;
  logic [EVT_CNT-1:0] qual;
  logic [IRQ_CNT-1:0] lineNext;

  genvar g;
  generate
    for (g = 0; g < EVT_CNT; g++) begin : gStat
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                statQ[g] <= 1'b0;
        else if (ctl.setMask[g])   statQ[g] <= 1'b1;
        else if (ctl.clrMask[g])   statQ[g] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        enQ <= '0;
    else if (ctl.enWr) enQ <= ctl.enVal;
  end

  assign qual = statQ & enQ;

  always_comb begin
    rdData = '0;
    for (int k = 0; k < EVT_CNT; k++) begin
      rdData[statPos(k)] = statQ[k];
      rdData[enPos(k)]   = enQ[k];
    end
  end

  always_comb begin
    lineNext = '0;
    for (int k = 0; k < EVT_CNT; k++)
      lineNext[evtLine(k)] = lineNext[evtLine(k)] | qual[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irqLine <= '0;
    else        irqLine <= lineNext;
  end
endmodule

// File: rtl/dma_evt_irq_agg.sv
module dma_evt_irq_agg
  import evt_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  input  logic [EVT_CNT-1:0] evtStrobe,
  output logic [REG_W-1:0]   rdData,
  output logic [IRQ_CNT-1:0] irqLine
);
  ctlStrobes_t ctl;

  evt_agg_ctl uCtl (
    .wrEn      (wrEn),
    .wrData    (wrData),
    .evtStrobe (evtStrobe),
    .ctl       (ctl)
  );

  evt_agg_dp uDp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .rdData  (rdData),
    .irqLine (irqLine)
  );
endmodule

// File: rtl/evt_agg_chk.sv
module evt_agg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic [9:0]  evtStrobe,
  input logic [31:0] rdData,
  input logic [2:0]  irqLine
);
  logic [9:0] statVec, enVec, clrVec, qualVec;
  logic       pastValid;

  assign statVec = {rdData[23:16], rdData[1:0]};
  assign enVec   = {rdData[31:24], rdData[9:8]};
  assign clrVec  = wrEn ? ~{wrData[23:16], wrData[1:0]} : 10'd0;
  assign qualVec = statVec & enVec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pastValid <= 1'b0;
    else        pastValid <= 1'b1;
  end

  AST_STROBE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evtStrobe) |=> ((statVec & $past(evtStrobe)) == $past(evtStrobe))); // R2
  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(statVec & ~clrVec)) |=> ((statVec & $past(statVec & ~clrVec)) == $past(statVec & ~clrVec))); // R3
  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> ((statVec & $past(clrVec & ~evtStrobe)) == 10'd0)); // R3
  AST_EN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> (enVec == $past({wrData[31:24], wrData[9:8]}))); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdData[15:10] == 6'd0) && (rdData[7:2] == 6'd0)); // R6
  AST_LINE0_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    pastValid |-> (irqLine[0] == $past(qualVec[1]))); // R7
  AST_LINE1_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    pastValid |-> (irqLine[1] == $past(qualVec[0] | qualVec[2] | qualVec[4] | qualVec[6] | qualVec[8]))); // R8
  AST_LINE2_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    pastValid |-> (irqLine[2] == $past(qualVec[3] | qualVec[5] | qualVec[7] | qualVec[9]))); // R9
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && ($past(qualVec) == 10'd0)) |-> (irqLine == 3'd0)); // R10
endmodule

bind dma_evt_irq_agg evt_agg_chk uChk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .evtStrobe (evtStrobe),
  .rdData    (rdData),
  .irqLine   (irqLine)
);

// File: tb/tb_dma_evt_irq_agg.sv
module tb_dma_evt_irq_agg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [9:0]  evtStrobe = '0;
  logic [31:0] rdData;
  logic [2:0]  irqLine;

  int testCnt = 0;
  int failCnt = 0;

  localparam logic [31:0] EN_ALL   = 32'hFF00_0300;
  localparam logic [31:0] STAT_ALL = 32'h00FF_0003;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_evt_irq_agg dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData),
    .evtStrobe(evtStrobe), .rdData(rdData), .irqLine(irqLine)
  );

  function automatic int sPos(input int k);
    return (k < 2) ? k : k + 14;
  endfunction

  function automatic logic [31:0] enImg(input logic [9:0] p);
    logic [31:0] v = '0;
    for (int k = 0; k < 10; k++) v[sPos(k) + 8] = p[k];
    return v;
  endfunction

  function automatic logic [2:0] lineOf(input logic [9:0] q);
    logic [2:0] v;
    v[0] = q[1];
    v[1] = q[0] | q[2] | q[4] | q[6] | q[8];
    v[2] = q[3] | q[5] | q[7] | q[9];
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doWrite(input logic [31:0] v);
    wrEn = 1'b1; wrData = v;
    step();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic pulse(input int k);
    evtStrobe = 10'd1 << k;
    step();
    evtStrobe = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testCnt++; failCnt++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset rdData", rdData, 32'h0);
    check("R11 reset irq", {29'd0, irqLine}, 32'h0);
    rst_n = 1'b1;
    step();

    // R6 and R3: all-ones write only lands in enable bits
    doWrite(32'hFFFF_FFFF);
    check("R6 reserved read zero", rdData, EN_ALL);
    doWrite(32'h0);

    for (int k = 0; k < 10; k++) begin
      logic [31:0] bitS;
      logic [2:0]  expL;
      bitS = 32'd1 << sPos(k);
      expL = lineOf(10'd1 << k);
      // enabled path
      doWrite(EN_ALL);
      pulse(k);
      check("R1 R2 status position", rdData, EN_ALL | bitS);
      check("R10 irq lags status", {29'd0, irqLine}, 32'h0);
      step();
      check("R7 R8 R9 line grouping", {29'd0, irqLine}, {29'd0, expL});
      doWrite(EN_ALL);
      check("R3 write zero clears", rdData, EN_ALL);
      check("R10 irq held one cycle after clear", {29'd0, irqLine}, {29'd0, expL});
      step();
      check("R10 irq drops after clear", {29'd0, irqLine}, 32'h0);
      // masked path
      doWrite(32'h0);
      pulse(k);
      check("R2 masked event still latched", rdData, bitS);
      step();
      check("R10 masked event no irq", {29'd0, irqLine}, 32'h0);
      // collision of strobe and clearing write
      wrEn = 1'b1; wrData = 32'h0; evtStrobe = 10'd1 << k;
      step();
      wrEn = 1'b0; evtStrobe = '0;
      check("R4 strobe beats clear", rdData, bitS);
      // masking drops the line; writing ones keeps status
      doWrite(EN_ALL | STAT_ALL);
      step();
      check("R5 irq with enable", {29'd0, irqLine}, {29'd0, expL});
      doWrite(STAT_ALL);
      check("R3 write one no effect", rdData, bitS);
      check("R10 irq held one cycle after mask", {29'd0, irqLine}, {29'd0, expL});
      step();
      check("R10 irq drops after mask", {29'd0, irqLine}, 32'h0);
      doWrite(32'h0);
    end

    // exhaustive enable sweep with every status set
    for (int p = 0; p < 1024; p++) begin
      wrEn = 1'b1; wrData = enImg(10'(p)) | STAT_ALL; evtStrobe = 10'h3FF;
      step();
      wrEn = 1'b0; wrData = '0; evtStrobe = '0;
      check("R5 enable image", rdData, enImg(10'(p)) | STAT_ALL);
      step();
      check("R8 sweep line pattern", {29'd0, irqLine}, {29'd0, lineOf(10'(p))});
      doWrite(32'h0);
    end

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule